// File: doc/BRIEF.md
# Key-Guarded Countdown Watchdog

This block is a watchdog timer behind a small register bus. A 20-bit counter counts down by one on each slow time-base strobe while it is running. When a running countdown reaches zero, the block raises a sticky interrupt flag and sends a one-clock reset request to the system reset logic. The counter then stays at zero until software loads it again.

Software never sets control bits directly. It writes 16-bit key words to a command register. Distinct keys halt the countdown, let it continue from its present value, open or close write access to the count register, acknowledge the interrupt, or refill the counter to its ceiling. The count register shows the upper 16 counter bits, so one register step is worth 16 ticks. Writes to the count register take effect only while access is open. This is how a firmware that has gone astray is kept from quietly pushing the deadline back. A forced system restart is made by halting, opening, loading a count of one, closing and resuming. The request then fires sixteen ticks later.

Top module: `kwdog_top`

## Requirements
- R1: After synchronous reset the counter holds 20'hFFFF0 (the count register reads 0x0000FFFF), the countdown is halted, count writes are closed, and irq and rst_req are low.
- R2: Writing key 0x3877 to the command register (offset 0x00) halts the countdown. Writing 0x4A4B makes it continue from the value it holds.
- R3: While running, the counter drops by exactly one on each clock edge where tick_en is high, and it does not change on edges where tick_en is low. A read of offset 0x04 returns counter bits [19:4] in bits [15:0], with bits [31:16] zero.
- R4: Key 0xAB00 opens the count register for writes and key 0xAB01 closes it. A count write while the register is closed leaves the counter unchanged.
- R5: While the count register is open, a write to offset 0x04 loads the counter with {wdata[15:0], 4'b0000}.
- R6: Key 0xDEAF loads the counter with 20'hFFFF0 whether the count register is open or closed.
- R7: When a running countdown steps from one to zero, irq rises and rst_req is high for exactly one clock. irq stays high and the counter stays at zero on later ticks, with no further rst_req pulse.
- R8: Key 0x7482 clears irq. If an expiry happens in the same cycle, the set takes priority.
- R9: A command word that is not one of the keys, or a write to any address other than 0x00 and 0x04, changes no state.
- R10: The sequence halt, open, write count 1, close, resume leads to rst_req after exactly 16 ticks.
- R11: A read of the command register returns zero.
- R12: With strict decoding (the default), a command word whose bits [31:16] are not zero is not taken as a key, even when its low half matches one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle time-base strobe that drives the countdown |
| req_valid | input | 1 | Bus access valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the current access, combinational |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | One-clock reset request at expiry |

## Verification
The bench builds the block with its defaults: a 20-bit counter with a 16-bit window, a 32-bit data bus and strict key decoding. Strict decoding makes the case of a key that has junk in its upper half reachable, and the 4-bit gap between the counter and the window makes the sixteen-tick step per register unit visible. The bench starts from a small loaded count so that the exact step to zero, the single reset-request pulse and the hold at zero are all reached within a few dozen ticks.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

   localparam logic [15:0] KEY_HALT  = 16'h3877;
   localparam logic [15:0] KEY_RUN   = 16'h4A4B;
   localparam logic [15:0] KEY_ACK   = 16'h7482;
   localparam logic [15:0] KEY_OPEN  = 16'hAB00;
   localparam logic [15:0] KEY_SEAL  = 16'hAB01;
   localparam logic [15:0] KEY_FILL  = 16'hDEAF;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_HALT,
      CMD_RUN,
      CMD_OPEN,
      CMD_SEAL,
      CMD_ACK,
      CMD_FILL
   } kw_cmd_e;

endpackage

// File: rtl/kwdog_keydec.sv
module kwdog_keydec
   import kwdog_pkg::*;
#(
   parameter int  DATA_W = 32,
   parameter bit  STRICT = 1'b1
) (
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output kw_cmd_e           cmd
);

   localparam int KEY_W = 16;

   logic upper_ok;

   generate
      if (STRICT && (DATA_W > KEY_W)) begin : g_strict
         assign upper_ok = (wdata[DATA_W-1:KEY_W] == '0);
      end else begin : g_loose
         assign upper_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      cmd = CMD_NONE;
      if (wr_stb && upper_ok) begin
         case (wdata[KEY_W-1:0])
            KEY_HALT: cmd = CMD_HALT;
            KEY_RUN:  cmd = CMD_RUN;
            KEY_OPEN: cmd = CMD_OPEN;
            KEY_SEAL: cmd = CMD_SEAL;
            KEY_ACK:  cmd = CMD_ACK;
            KEY_FILL: cmd = CMD_FILL;
            default:  cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/kwdog_ctrl.sv
module kwdog_ctrl
   import kwdog_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  kw_cmd_e cmd,
   output logic    run_q,
   output logic    lock_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         lock_q <= 1'b1;
      end else begin
         case (cmd)
            CMD_HALT: run_q  <= 1'b0;
            CMD_RUN:  run_q  <= 1'b1;
            CMD_OPEN: lock_q <= 1'b0;
            CMD_SEAL: lock_q <= 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter #(
   parameter int CNT_W  = 20,
   parameter int VIEW_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              tick_en,
   input  logic              load_en,
   input  logic [VIEW_W-1:0] load_val,
   input  logic              fill,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              expire
);

   localparam int SHIFT = CNT_W - VIEW_W;

   logic [CNT_W-1:0] ceiling;
   logic [CNT_W-1:0] load_word;

   generate
      if (SHIFT == 0) begin : g_flat
         assign ceiling   = '1;
         assign load_word = load_val;
      end else begin : g_shift
         assign ceiling   = {{VIEW_W{1'b1}}, {SHIFT{1'b0}}};
         assign load_word = {load_val, {SHIFT{1'b0}}};
      end
   endgenerate

   logic step;
   assign step   = run && tick_en && (cnt_q != '0) && !load_en && !fill;
   assign expire = step && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= ceiling;
      else if (fill)    cnt_q <= ceiling;
      else if (load_en) cnt_q <= load_word;
      else if (step)    cnt_q <= cnt_q - CNT_W'(1);
   end

endmodule

// File: rtl/kwdog_expiry.sv
module kwdog_expiry (
   input  logic clk,
   input  logic rst,
   input  logic expire,
   input  logic ack,
   output logic irq,
   output logic rst_req
);

   always_ff @(posedge clk) begin
      if (rst) begin
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= expire;
         if (expire)   irq <= 1'b1;
         else if (ack) irq <= 1'b0;
      end
   end

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
   import kwdog_pkg::*;
#(
   parameter int CNT_W   = 20,
   parameter int VIEW_W  = 16,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter bit STRICT  = 1'b1,
   parameter logic [ADDR_W-1:0] CMD_OFS = 'h00,
   parameter logic [ADDR_W-1:0] CNT_OFS = 'h04
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              rst_req
);

   generate
      if (VIEW_W > CNT_W) begin : g_bad_view
         $error("kwdog_top: VIEW_W must not exceed CNT_W");
      end
      if (DATA_W < VIEW_W || VIEW_W < 16) begin : g_bad_data
         $error("kwdog_top: DATA_W must hold the 16-bit keys and the count window");
      end
      if (CMD_OFS == CNT_OFS) begin : g_bad_map
         $error("kwdog_top: register offsets must differ");
      end
   endgenerate

   logic cmd_wr, cnt_wr, cnt_rd;
   assign cmd_wr = req_valid && req_write  && (req_addr == CMD_OFS);
   assign cnt_wr = req_valid && req_write  && (req_addr == CNT_OFS);
   assign cnt_rd = req_valid && !req_write && (req_addr == CNT_OFS);

   kw_cmd_e          cmd;
   logic             run_q, lock_q;
   logic             cnt_load, fill, expire;
   logic [CNT_W-1:0] cnt_q;

   kwdog_keydec #(.DATA_W(DATA_W), .STRICT(STRICT)) u_dec (
      .wr_stb (cmd_wr),
      .wdata  (req_wdata),
      .cmd    (cmd)
   );

   kwdog_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .cmd    (cmd),
      .run_q  (run_q),
      .lock_q (lock_q)
   );

   assign cnt_load = cnt_wr && !lock_q;
   assign fill     = (cmd == CMD_FILL);

   kwdog_counter #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .run      (run_q),
      .tick_en  (tick_en),
      .load_en  (cnt_load),
      .load_val (req_wdata[VIEW_W-1:0]),
      .fill     (fill),
      .cnt_q    (cnt_q),
      .expire   (expire)
   );

   kwdog_expiry u_exp (
      .clk     (clk),
      .rst     (rst),
      .expire  (expire),
      .ack     (cmd == CMD_ACK),
      .irq     (irq),
      .rst_req (rst_req)
   );

   assign rd_data = cnt_rd ? DATA_W'(cnt_q[CNT_W-1 -: VIEW_W]) : '0;

endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst,
   input logic             tick_en,
   input logic             run_q,
   input logic             lock_q,
   input logic             cnt_wr,
   input logic             cnt_load,
   input logic             fill,
   input logic [CNT_W-1:0] cnt_q,
   input logic             irq,
   input logic             rst_req,
   input logic             ack_cmd
);

   // R7
   rst_req_single_chk: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> !rst_req);

   // R7
   rst_req_cause_chk: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> (irq && cnt_q == '0));

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (irq && !ack_cmd) |=> irq);

   // R2
   halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_q && !cnt_load && !fill) |=> $stable(cnt_q));

   // R3
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && tick_en && cnt_q != '0 && !cnt_load && !fill)
         |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R4
   sealed_write_chk: assert property (@(posedge clk) disable iff (rst)
      (lock_q && cnt_wr && !fill && !(run_q && tick_en)) |=> $stable(cnt_q));

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && !cnt_load && !fill) |=> (cnt_q == '0));

endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick_en  (tick_en),
   .run_q    (run_q),
   .lock_q   (lock_q),
   .cnt_wr   (cnt_wr),
   .cnt_load (cnt_load),
   .fill     (fill),
   .cnt_q    (cnt_q),
   .irq      (irq),
   .rst_req  (rst_req),
   .ack_cmd  (cmd == kwdog_pkg::CMD_ACK)
);

// File: tb/tb_kwdog_top.sv
module tb_kwdog_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        irq, rst_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   kwdog_top dut (
      .clk(clk), .rst(rst), .tick_en(tick_en),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
   );

   typedef struct packed {
      logic [1:0]  kind;    // 0 command, 1 count write, 2 ticks, 3 none
      logic [31:0] data;
      logic [15:0] exp_cnt;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{2'd3, 32'h0,         16'hFFFF, 1'b0, 8'd1},  // R1 reset value
      '{2'd2, 32'd3,         16'hFFFF, 1'b0, 8'd2},  // R2 halted at reset
      '{2'd0, 32'h4A4B,      16'hFFFF, 1'b0, 8'd2},  // R2 resume
      '{2'd2, 32'd1,         16'hFFFE, 1'b0, 8'd3},  // R3 one tick
      '{2'd0, 32'h3877,      16'hFFFE, 1'b0, 8'd2},  // R2 halt
      '{2'd2, 32'd20,        16'hFFFE, 1'b0, 8'd2},  // R2 ticks ignored
      '{2'd1, 32'h0010,      16'hFFFE, 1'b0, 8'd4},  // R4 sealed write
      '{2'd0, 32'hAB00,      16'hFFFE, 1'b0, 8'd4},  // R4 open
      '{2'd1, 32'h0010,      16'h0010, 1'b0, 8'd5},  // R5 load
      '{2'd0, 32'hAB01,      16'h0010, 1'b0, 8'd4},  // R4 seal
      '{2'd1, 32'h0020,      16'h0010, 1'b0, 8'd4},  // R4 sealed again
      '{2'd0, 32'h1234,      16'h0010, 1'b0, 8'd9},  // R9 junk key
      '{2'd0, 32'h0001_AB00, 16'h0010, 1'b0, 8'd12}, // R12 dirty upper half
      '{2'd1, 32'h0030,      16'h0010, 1'b0, 8'd12}, // R12 still sealed
      '{2'd0, 32'h4A4B,      16'h0010, 1'b0, 8'd2},  // R2 resume from value
      '{2'd2, 32'd1,         16'h000F, 1'b0, 8'd3},  // R3
      '{2'd2, 32'd16,        16'h000E, 1'b0, 8'd3},  // R3 sixteen ticks
      '{2'd0, 32'hDEAF,      16'hFFFF, 1'b0, 8'd6}   // R6 fill while sealed
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      #1 d = rd_data;
      req_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick_en = 1'b1;
         repeat (n) @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 outputs after reset
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 rst_req", 32'(rst_req), 32'd0);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i].kind)
            2'd0: wr(8'h00, VEC[i].data);
            2'd1: wr(8'h04, VEC[i].data);
            2'd2: ticks(int'(VEC[i].data));
            default: ;
         endcase
         rd(8'h04, d);
         check($sformatf("R%0d vec %0d count", VEC[i].req, i), d, 32'(VEC[i].exp_cnt));
         check($sformatf("R%0d vec %0d irq", VEC[i].req, i), 32'(irq), 32'(VEC[i].exp_irq));
      end

      // R10 forced restart sequence
      wr(8'h00, 32'h3877);
      wr(8'h00, 32'hAB00);
      wr(8'h04, 32'h0001);
      wr(8'h00, 32'hAB01);
      wr(8'h00, 32'h4A4B);
      ticks(15);
      rd(8'h04, d);
      check("R10 count before last tick", d, 32'h0);
      check("R10 no early rst_req", 32'(rst_req), 32'd0);
      check("R10 no early irq", 32'(irq), 32'd0);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      check("R7 rst_req on sixteenth tick", 32'(rst_req), 32'd1);
      check("R7 irq on expiry", 32'(irq), 32'd1);
      @(negedge clk);
      check("R7 rst_req one clock", 32'(rst_req), 32'd0);
      check("R7 irq sticky", 32'(irq), 32'd1);
      ticks(5);
      check("R7 no second pulse", 32'(rst_req), 32'd0);
      rd(8'h04, d);
      check("R7 holds zero", d, 32'h0);

      // R11 command register reads zero
      rd(8'h00, d);
      check("R11 command read", d, 32'h0);

      // R9 fill key at an unmapped address
      wr(8'h08, 32'hDEAF);
      rd(8'h04, d);
      check("R9 stray address", d, 32'h0);

      // R8 acknowledge
      wr(8'h00, 32'h7482);
      check("R8 irq cleared", 32'(irq), 32'd0);
      ticks(3);
      check("R8 stays clear at zero", 32'(irq), 32'd0);

      // R1 reset in the middle of operation
      wr(8'h00, 32'hAB00);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk); rst = 1'b0;
      rd(8'h04, d);
      check("R1 count after reset", d, 32'h0000FFFF);
      ticks(4);
      rd(8'h04, d);
      check("R1 halted after reset", d, 32'h0000FFFF);
      wr(8'h04, 32'h0005);
      rd(8'h04, d);
      check("R1 sealed after reset", d, 32'h0000FFFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule